// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit product. It takes one recoded step per clock and needs no array multiplier. The caller raises `start_i` for one cycle with both operands while the block is idle. The block then runs exactly `WIDTH` steps, pulses `done_o`, and keeps the product on `product_o` until the next accepted start.

When a start is accepted, each operand is given an implied zero below its least significant bit, and the block counts how many times adjacent bits differ. The operand with fewer such changes becomes the scanned multiplier, because fewer changes mean fewer add and subtract steps. On a tie, operand A is scanned. The other operand becomes the multiplicand. The working state has four parts: an upper accumulator, a lower product half, the shifting multiplier and one history bit.

In each step the block looks at the multiplier's low bit together with the history bit. The pair (1,0) subtracts the multiplicand from the accumulator, the pair (0,1) adds it, and equal bits leave the accumulator unchanged. The whole accumulator/lower pair is then shifted right arithmetically. The add and subtract use one guard bit, so the sign shifted in is that of the exact sum. This keeps the most negative operands correct.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is held and in the cycle after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` sampled high while `busy_o` is low is accepted, and `busy_o` is high in the following cycle.
- R3: If a start is accepted at clock edge k, `busy_o` stays high for exactly `WIDTH` cycles and `done_o` is high in the cycle that follows clock edge k+`WIDTH`.
- R4: `done_o` is high for exactly one cycle per accepted start.
- R5: When `done_o` is high, `product_o` equals the signed product of `op_a_i` and `op_b_i` as they were at the accepted start, as a `2*WIDTH`-bit two's-complement value, for every operand pair and in either operand order.
- R6: A `start_i` pulse and operand changes while `busy_o` is high are ignored: the running product and its timing do not change, and no extra `done_o` follows.
- R7: While the block is idle and no start is accepted, `product_o` keeps its value from cycle to cycle.
- R8: The product never overflows. With both operands at the most negative value, the result is +2^(2*WIDTH-2), which is 8'h40 for `WIDTH` = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled only when idle |
| op_a_i | input | WIDTH | First signed operand |
| op_b_i | input | WIDTH | Second signed operand |
| busy_o | output | 1 | High while steps are running |
| done_o | output | 1 | One-cycle pulse when the product is final |
| product_o | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
The bench builds the block at the default `WIDTH` of 4. At that width, all 256 signed operand pairs can be issued back to back, with each new start placed in the done cycle of the one before. This covers every recoding pattern, every operand choice and tie, and both most-negative corners, which would be unreachable at wider widths. Directed runs add start pulses with new operands while the block is busy, and they watch the held product over idle cycles.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Action chosen for one recoding step
    typedef enum logic [1:0] {
        BOOTH_HOLD = 2'd0,
        BOOTH_ADD  = 2'd1,
        BOOTH_SUB  = 2'd2
    } booth_act_e;

    // Sequencer states
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Radix-2 recoding of the (current bit, history bit) pair
    function automatic booth_act_e booth_decode(input logic cur_bit, input logic prev_bit);
        booth_act_e act;
        unique case ({cur_bit, prev_bit})
            2'b10:   act = BOOTH_SUB;
            2'b01:   act = BOOTH_ADD;
            default: act = BOOTH_HOLD;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/booth_operand_sel.sv
module booth_operand_sel #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] scan_op,
    output logic [WIDTH-1:0] addend_op
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [WIDTH-1:0] edge_a;
    logic [WIDTH-1:0] edge_b;
    logic [CW-1:0]    cnt_a;
    logic [CW-1:0]    cnt_b;
    logic             take_b;

    // Bit changes of the operand with a zero appended below it
    assign edge_a = opa ^ {opa[WIDTH-2:0], 1'b0};
    assign edge_b = opb ^ {opb[WIDTH-2:0], 1'b0};

    always_comb begin
        cnt_a = '0;
        cnt_b = '0;
        for (int i = 0; i < WIDTH; i++) begin
            cnt_a = cnt_a + CW'(edge_a[i]);
            cnt_b = cnt_b + CW'(edge_b[i]);
        end
    end

    // Fewer changes means fewer add/sub steps; ties keep A as multiplier
    assign take_b    = (cnt_b < cnt_a);
    assign scan_op   = take_b ? opb : opa;
    assign addend_op = take_b ? opa : opb;

endmodule

// File: rtl/booth_step_unit.sv
module booth_step_unit #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] acc_u,
    input  logic [WIDTH-1:0] low_v,
    input  logic [WIDTH-1:0] mcand,
    input  logic             x_lsb,
    input  logic             x_hist,
    output logic [WIDTH-1:0] acc_u_nxt,
    output logic [WIDTH-1:0] low_v_nxt
);
    import booth_pkg::*;

    booth_act_e       act;
    logic [WIDTH:0]   u_ext;
    logic [WIDTH:0]   y_ext;
    logic [WIDTH:0]   sum;

    assign act   = booth_decode(x_lsb, x_hist);
    assign u_ext = {acc_u[WIDTH-1], acc_u};
    assign y_ext = {mcand[WIDTH-1], mcand};

    // Guard bit keeps the exact sign of the sum for the shift
    always_comb begin
        unique case (act)
            BOOTH_ADD: sum = u_ext + y_ext;
            BOOTH_SUB: sum = u_ext + (~y_ext) + (WIDTH+1)'(1);
            default:   sum = u_ext;
        endcase
    end

    // Arithmetic right shift of {sum, V} by one
    assign acc_u_nxt = sum[WIDTH:1];
    assign low_v_nxt = {sum[0], low_v[WIDTH-1:1]};

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    import booth_pkg::*;

    localparam int CNTW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNTW-1:0] LAST_STEP = CNTW'(WIDTH - 1);

    seq_state_e      state;
    logic [CNTW-1:0] step_cnt;
    logic            last;
    logic            done_q;

    assign load = (state == SEQ_IDLE) && start;
    assign step = (state == SEQ_RUN);
    assign last = step && (step_cnt == LAST_STEP);
    assign busy = step;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            step_cnt <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= last;
            if (load) begin
                state    <= SEQ_RUN;
                step_cnt <= '0;
            end else if (last) begin
                state    <= SEQ_IDLE;
                step_cnt <= '0;
            end else if (step) begin
                step_cnt <= step_cnt + CNTW'(1);
            end
        end
    end

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [WIDTH-1:0]   op_a_i,
    input  logic [WIDTH-1:0]   op_b_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [2*WIDTH-1:0] product_o
);
    typedef struct packed {
        logic [WIDTH-1:0] u;
        logic [WIDTH-1:0] v;
        logic [WIDTH-1:0] x;
        logic             xm1;
        logic [WIDTH-1:0] y;
    } work_t;

    work_t            work;
    logic             load;
    logic             step;
    logic [WIDTH-1:0] sel_x;
    logic [WIDTH-1:0] sel_y;
    logic [WIDTH-1:0] u_nxt;
    logic [WIDTH-1:0] v_nxt;

    booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .load  (load),
        .step  (step),
        .busy  (busy_o),
        .done  (done_o)
    );

    booth_operand_sel #(.WIDTH(WIDTH)) u_sel (
        .opa       (op_a_i),
        .opb       (op_b_i),
        .scan_op   (sel_x),
        .addend_op (sel_y)
    );

    booth_step_unit #(.WIDTH(WIDTH)) u_step (
        .acc_u     (work.u),
        .low_v     (work.v),
        .mcand     (work.y),
        .x_lsb     (work.x[0]),
        .x_hist    (work.xm1),
        .acc_u_nxt (u_nxt),
        .low_v_nxt (v_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work <= '0;
        end else if (load) begin
            work.u   <= '0;
            work.v   <= '0;
            work.x   <= sel_x;
            work.xm1 <= 1'b0;
            work.y   <= sel_y;
        end else if (step) begin
            work.u   <= u_nxt;
            work.v   <= v_nxt;
            work.x   <= {work.x[WIDTH-1], work.x[WIDTH-1:1]};
            work.xm1 <= work.x[0];
        end
    end

    assign product_o = {work.u, work.v};

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int WIDTH = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic [WIDTH-1:0]   op_a_i,
    input logic [WIDTH-1:0]   op_b_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [2*WIDTH-1:0] product_o
);
    localparam int RW = $clog2(WIDTH + 2) + 1;

    logic               rst_q;
    logic [RW-1:0]      run_len;
    logic [2*WIDTH-1:0] ref_prod;
    logic               accept;

    assign accept = !busy_o && start_i;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            run_len  <= '0;
            ref_prod <= '0;
        end else begin
            if (accept) begin
                run_len  <= '0;
                ref_prod <= $signed({{WIDTH{op_a_i[WIDTH-1]}}, op_a_i})
                          * $signed({{WIDTH{op_b_i[WIDTH-1]}}, op_b_i});
            end else if (busy_o) begin
                run_len <= run_len + RW'(1);
            end
        end
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_q) begin
            reset_state_chk: assert (!busy_o && !done_o && product_o == '0)
                else $error("reset state wrong");
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_o);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_len == RW'(WIDTH)) && !busy_o);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5
    product_value_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> product_o == ref_prod);

    // R6
    busy_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |-> !done_o);

    // R7
    hold_product_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(product_o));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.WIDTH(WIDTH)) u_booth_chk (.*);

// File: tb/test_booth_seq_mul.sv
module test_booth_seq_mul;
    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [W-1:0]  op_a_i = '0;
    logic [W-1:0]  op_b_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [PW-1:0] product_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit finished = 1'b0;
    bit prev_done = 1'b0;

    logic [PW-1:0] exp_q[$];
    int            t_q[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    booth_seq_mul #(.WIDTH(W)) i_booth_seq_mul (
        .clk(clk), .rst(rst), .start_i(start_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i),
        .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        int ia = int'($signed(a));
        int ib = int'($signed(b));
        int pr = ia * ib;
        return pr[PW-1:0];
    endfunction

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        start_i = 1'b1;
        op_a_i  = a;
        op_b_i  = b;
        exp_q.push_back(ref_mul(a, b));
        t_q.push_back(cyc);
        @(negedge clk);
        start_i = 1'b0;
        // R2: busy in the cycle after acceptance
        check(busy_o === 1'b1, "R2", longint'(busy_o), 1);
    endtask

    task automatic issue_noisy(input logic [W-1:0] a, input logic [W-1:0] b);
        issue(a, b);
        // R6: start with new operands while busy must be ignored
        repeat (2) begin
            if (busy_o) begin
                start_i = 1'b1;
                op_a_i  = ~a;
                op_b_i  = b + W'(1);
            end
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    task automatic hold_check(input logic [PW-1:0] want, input string req);
        logic [PW-1:0] held;
        while (!done_o) @(negedge clk);
        check(product_o === want, req, longint'(product_o), longint'(want));
        held = product_o;
        repeat (5) begin
            @(negedge clk);
            // R7: idle product stays put
            check(product_o === held, "R7", longint'(product_o), longint'(held));
        end
    endtask

    // Monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) begin
                // R4: done lasts one cycle
                check(!done_o, "R4", longint'(done_o), 0);
            end
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 extra done", 1, 0);
                end else begin
                    logic [PW-1:0] e;
                    int t0;
                    e  = exp_q.pop_front();
                    t0 = t_q.pop_front();
                    check(product_o === e, "R5", longint'(product_o), longint'(e));
                    check(cyc == t0 + 1 + W, "R3", longint'(cyc - t0), longint'(1 + W));
                end
            end
            prev_done = done_o;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(!busy_o && !done_o && product_o == '0, "R1", longint'(product_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && product_o == '0, "R1", longint'(product_o), 0);

        issue_noisy(W'(3), W'(-5));
        hold_check(ref_mul(W'(3), W'(-5)), "R6");

        // R8: most negative squared
        issue({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}});
        hold_check(PW'(1) << (PW - 2), "R8");

        // R5: every operand pair, back to back
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                issue(W'(a), W'(b));
            end
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", exp_q.size(), 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule